// File: doc/BRIEF.md
# Two-Window Overlay Position Blender

This block sits at the end of a display pipeline. Every clock it takes the current raster coordinate and one already-fetched 32-bit ARGB pixel for each of two overlay windows. It decides which windows cover that coordinate and produces one 24-bit RGB output pixel. Window 0 is the lower layer and is composited over a programmable background colour. Window 1 is the upper layer and is composited over that result. Each window is described by a start corner and a size. The block derives the inclusive far corner on its own.

Each window has an enable bit and an alpha source. The alpha comes either from the pixel's own alpha byte or from one of two fixed per-window levels, a transparent level (0x00) and an opaque level (0xFF). The upper window also supports a colour key with a compare mask, which makes matching pixels transparent. The lower window has no key.

The datapath is a fixed two-stage pipeline and has no state machine. The first stage does the hit test, the key match, alpha selection and the lower blend. The second stage does the upper blend. The output register holds the result.

Top module: `ovl_blend2`

## Requirements
- R1: While reset is asserted, and until new data has passed through the pipeline, `out_rgb` is 0x000000.
- R2: A window covers column x when start ≤ x ≤ last, with last = start + size − 1. The same rule applies to rows. When start + size is zero, last is clamped to 0, so a zero-size window at start 0 covers coordinate 0. A zero-size window at a non-zero start covers nothing.
- R3: A window whose enable input is low never affects the output, whatever its rectangle and pixel.
- R4: When no enabled window covers the coordinate, the output equals `bg_rgb`.
- R5: Where both windows cover the coordinate, window 1 is the upper layer. With opaque alpha on window 1 the output is window 1's RGB.
- R6: When the per-pixel alpha input is high, the alpha is bits 31:24 of that window's pixel. Each channel is blended as floor((a·upper + (255−a)·lower)/255). Red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R7: When the per-pixel alpha input is low, the pixel's bits 31:24 are ignored. The alpha is then 0x00 if the fixed-select input is low and 0xFF if it is high.
- R8: When `key_en` is high and ((window 1 RGB XOR `key_val`) AND `key_mask`) is zero, window 1 is treated as transparent. Window 0 is never keyed.
- R9: Window 0 is blended over the background with its own alpha, using the R6 formula.
- R10: Inputs presented before a rising edge appear on `out_rgb` after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_x | input | CW | Raster column |
| ras_y | input | CW | Raster row |
| bg_rgb | input | 24 | Background colour |
| w0_en | input | 1 | Window 0 enable |
| w0_left | input | CW | Window 0 start column |
| w0_top | input | CW | Window 0 start row |
| w0_wid | input | CW | Window 0 width |
| w0_hgt | input | CW | Window 0 height |
| w0_pixalpha | input | 1 | Window 0 uses pixel alpha |
| w0_fixsel | input | 1 | Window 0 fixed alpha select (0: 0x00, 1: 0xFF) |
| w0_pix | input | 32 | Window 0 ARGB pixel |
| w1_en | input | 1 | Window 1 enable |
| w1_left | input | CW | Window 1 start column |
| w1_top | input | CW | Window 1 start row |
| w1_wid | input | CW | Window 1 width |
| w1_hgt | input | CW | Window 1 height |
| w1_pixalpha | input | 1 | Window 1 uses pixel alpha |
| w1_fixsel | input | 1 | Window 1 fixed alpha select |
| w1_pix | input | 32 | Window 1 ARGB pixel |
| key_en | input | 1 | Colour key enable for window 1 |
| key_val | input | 24 | Colour key value |
| key_mask | input | 24 | Colour key compare mask |
| out_rgb | output | 24 | Composited pixel |

## Verification
The bench sweeps small rasters across rectangle edges, so off-by-one errors show up at the first and last covered columns and rows. A design that treats the far corner as exclusive, or that wraps it instead of clamping, would paint one column too few or a stray pixel. Overlap regions with opaque and graded alpha expose swapped layer priority and a blend that shifts by 8 in place of dividing by 255. A shift would darken opaque pixels by one code. Key scenarios set mismatching bits both inside and outside the mask, and also give window 0 the key colour. A design that ignored the mask, or keyed the wrong window, would show or hide the wrong layer there.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef logic [23:0] rgb_t;

    // Alpha source choice for one window: pixel byte or a fixed level.
    function automatic logic [7:0] pick_alpha(
        input logic        use_pix,
        input logic        fix_hi,
        input logic [31:0] pix,
        input logic [7:0]  lvl_lo,
        input logic [7:0]  lvl_hi
    );
        if (use_pix)
            return pix[31:24];
        return fix_hi ? lvl_hi : lvl_lo;
    endfunction

endpackage

// File: rtl/ovl_corner.sv
module ovl_corner #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] size,
    output logic [CW:0]   last
);
    logic [CW:0] sum;

    always_comb begin
        sum = {1'b0, start} + {1'b0, size};
        // Inclusive far edge; clamp at zero when nothing is placed.
        last = (sum == '0) ? '0 : sum - 1'b1;
    end
endmodule

// File: rtl/ovl_hit.sv
module ovl_hit #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] left,
    input  logic [CW-1:0] top,
    input  logic [CW-1:0] wid,
    input  logic [CW-1:0] hgt,
    input  logic [CW-1:0] px,
    input  logic [CW-1:0] py,
    output logic          hit
);
    logic [CW:0] last_x;
    logic [CW:0] last_y;

    ovl_corner #(.CW(CW)) u_cx (.start(left), .size(wid), .last(last_x));
    ovl_corner #(.CW(CW)) u_cy (.start(top),  .size(hgt), .last(last_y));

    always_comb begin
        hit = en
            && (px >= left) && ({1'b0, px} <= last_x)
            && (py >= top)  && ({1'b0, py} <= last_y);
    end

    // R3: a disabled window never reports coverage
    a_r3_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !hit);

    // R2: a reported hit lies inside the derived inclusive rectangle
    a_r2_hit_inside: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ({1'b0, px} <= last_x && {1'b0, py} <= last_y
                 && px >= left && py >= top));
endmodule

// File: rtl/ovl_mix.sv
module ovl_mix #(
    parameter int NCH = 3,
    parameter int CHW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CHW-1:0]     alpha,
    input  logic [NCH*CHW-1:0] upper,
    input  logic [NCH*CHW-1:0] lower,
    output logic [NCH*CHW-1:0] result
);
    localparam int PW = 2 * CHW + 1;
    localparam logic [CHW-1:0] MAXV = {CHW{1'b1}};

    logic [CHW-1:0] inv_a;
    assign inv_a = MAXV - alpha;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [PW-1:0] acc;
        assign acc = PW'(alpha) * PW'(upper[c*CHW +: CHW])
                   + PW'(inv_a) * PW'(lower[c*CHW +: CHW]);
        assign result[c*CHW +: CHW] = CHW'(acc / PW'(MAXV));
    end

    // R6: full alpha passes the upper pixel unchanged
    a_r6_full_alpha_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha == MAXV) |-> (result == upper));

    // R6: zero alpha passes the lower pixel unchanged
    a_r6_zero_alpha_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (alpha == '0) |-> (result == lower));
endmodule

// File: rtl/ovl_blend2.sv
module ovl_blend2 #(
    parameter int          CW     = 12,
    parameter logic [7:0]  ALPHA0 = 8'h00,
    parameter logic [7:0]  ALPHA1 = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ras_x,
    input  logic [CW-1:0] ras_y,
    input  logic [23:0]   bg_rgb,
    input  logic          w0_en,
    input  logic [CW-1:0] w0_left,
    input  logic [CW-1:0] w0_top,
    input  logic [CW-1:0] w0_wid,
    input  logic [CW-1:0] w0_hgt,
    input  logic          w0_pixalpha,
    input  logic          w0_fixsel,
    input  logic [31:0]   w0_pix,
    input  logic          w1_en,
    input  logic [CW-1:0] w1_left,
    input  logic [CW-1:0] w1_top,
    input  logic [CW-1:0] w1_wid,
    input  logic [CW-1:0] w1_hgt,
    input  logic          w1_pixalpha,
    input  logic          w1_fixsel,
    input  logic [31:0]   w1_pix,
    input  logic          key_en,
    input  logic [23:0]   key_val,
    input  logic [23:0]   key_mask,
    output logic [23:0]   out_rgb
);
    import ovl_pkg::*;

    localparam int NWIN = 2;

    logic          en_a   [NWIN];
    logic [CW-1:0] left_a [NWIN];
    logic [CW-1:0] top_a  [NWIN];
    logic [CW-1:0] wid_a  [NWIN];
    logic [CW-1:0] hgt_a  [NWIN];
    logic [NWIN-1:0] hit;

    assign en_a[0] = w0_en;   assign en_a[1] = w1_en;
    assign left_a[0] = w0_left; assign left_a[1] = w1_left;
    assign top_a[0] = w0_top;   assign top_a[1] = w1_top;
    assign wid_a[0] = w0_wid;   assign wid_a[1] = w1_wid;
    assign hgt_a[0] = w0_hgt;   assign hgt_a[1] = w1_hgt;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ovl_hit #(.CW(CW)) u_hit (
            .clk(clk), .rst_n(rst_n), .en(en_a[w]),
            .left(left_a[w]), .top(top_a[w]), .wid(wid_a[w]), .hgt(hgt_a[w]),
            .px(ras_x), .py(ras_y), .hit(hit[w])
        );
    end

    // Stage 1: selection and lower blend
    logic       key_match;
    logic [7:0] a_lo;
    logic [7:0] a_hi;
    rgb_t       base_c;

    always_comb begin
        key_match = key_en && (((w1_pix[23:0] ^ key_val) & key_mask) == '0);
        a_lo = hit[0] ? pick_alpha(w0_pixalpha, w0_fixsel, w0_pix, ALPHA0, ALPHA1) : 8'h00;
        a_hi = (hit[1] && !key_match)
             ? pick_alpha(w1_pixalpha, w1_fixsel, w1_pix, ALPHA0, ALPHA1) : 8'h00;
    end

    ovl_mix #(.NCH(3), .CHW(8)) u_mix_lo (
        .clk(clk), .rst_n(rst_n), .alpha(a_lo),
        .upper(w0_pix[23:0]), .lower(bg_rgb), .result(base_c)
    );

    rgb_t       base_q;
    rgb_t       up_q;
    logic [7:0] a_hi_q;
    rgb_t       fin_c;
    rgb_t       out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            up_q   <= '0;
            a_hi_q <= '0;
            out_q  <= '0;
        end else begin
            base_q <= base_c;
            up_q   <= w1_pix[23:0];
            a_hi_q <= a_hi;
            out_q  <= fin_c;
        end
    end

    // Stage 2: upper blend
    ovl_mix #(.NCH(3), .CHW(8)) u_mix_hi (
        .clk(clk), .rst_n(rst_n), .alpha(a_hi_q),
        .upper(up_q), .lower(base_q), .result(fin_c)
    );

    assign out_rgb = out_q;

    // R4: uncovered coordinate shows the background two edges later
    a_r4_background: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> ##1 (out_rgb == $past(bg_rgb, 2)));

    // R8: keyed upper pixel alone over background leaves background visible
    a_r8_key_hides: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == 2'b10 && key_en
         && (((w1_pix[23:0] ^ key_val) & key_mask) == '0))
        |=> ##1 (out_rgb == $past(bg_rgb, 2)));

    // R1: output cleared while in reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (out_rgb == '0));
endmodule

// File: tb/ovl_blend2_tb_top.sv
module ovl_blend2_tb_top;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [CW-1:0] ras_x = '0, ras_y = '0;
    logic [23:0]   bg_rgb = 24'h102030;
    logic          w0_en = 0, w1_en = 0;
    logic [CW-1:0] w0_left = 0, w0_top = 0, w0_wid = 0, w0_hgt = 0;
    logic [CW-1:0] w1_left = 0, w1_top = 0, w1_wid = 0, w1_hgt = 0;
    logic          w0_pixalpha = 0, w0_fixsel = 1, w1_pixalpha = 0, w1_fixsel = 1;
    logic [31:0]   w0_pix = 0, w1_pix = 0;
    logic          key_en = 0;
    logic [23:0]   key_val = 0, key_mask = 0;
    logic [23:0]   out_rgb;

    ovl_blend2 #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_x(ras_x), .ras_y(ras_y), .bg_rgb(bg_rgb),
        .w0_en(w0_en), .w0_left(w0_left), .w0_top(w0_top), .w0_wid(w0_wid),
        .w0_hgt(w0_hgt), .w0_pixalpha(w0_pixalpha), .w0_fixsel(w0_fixsel),
        .w0_pix(w0_pix),
        .w1_en(w1_en), .w1_left(w1_left), .w1_top(w1_top), .w1_wid(w1_wid),
        .w1_hgt(w1_hgt), .w1_pixalpha(w1_pixalpha), .w1_fixsel(w1_fixsel),
        .w1_pix(w1_pix),
        .key_en(key_en), .key_val(key_val), .key_mask(key_mask),
        .out_rgb(out_rgb)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [23:0] exp_q[$];
    string       tag_q[$];

    // pixel pattern controls
    logic [7:0]  a0_byte = 8'hFF, a1_byte = 8'hFF;
    logic        vary_alpha = 0;
    logic        fixed_w1 = 0;
    logic [23:0] w1_const = 0;
    logic        fixed_w0 = 0;
    logic [23:0] w0_const = 0;

    function automatic int last_of(int s, int z);
        return (s + z == 0) ? 0 : s + z - 1;
    endfunction

    function automatic bit covers(bit en, int l, int t, int w, int h, int x, int y);
        return en && x >= l && x <= last_of(l, w) && y >= t && y <= last_of(t, h);
    endfunction

    function automatic logic [23:0] mixm(int a, logic [23:0] u, logic [23:0] l);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int uu, ll;
            uu = u[c*8 +: 8];
            ll = l[c*8 +: 8];
            r[c*8 +: 8] = 8'((a * uu + (255 - a) * ll) / 255);
        end
        return r;
    endfunction

    function automatic int alpha_of(bit usep, bit fhi, logic [31:0] p);
        if (usep) return int'(p[31:24]);
        return fhi ? 255 : 0;
    endfunction

    function automatic logic [23:0] model();
        logic [23:0] base;
        bit h0, h1, km;
        int a;
        h0 = covers(w0_en, w0_left, w0_top, w0_wid, w0_hgt, ras_x, ras_y);
        h1 = covers(w1_en, w1_left, w1_top, w1_wid, w1_hgt, ras_x, ras_y);
        km = key_en && (((w1_pix[23:0] ^ key_val) & key_mask) == 24'h0);
        base = bg_rgb;
        if (h0) base = mixm(alpha_of(w0_pixalpha, w0_fixsel, w0_pix), w0_pix[23:0], base);
        if (h1 && !km) begin
            a = alpha_of(w1_pixalpha, w1_fixsel, w1_pix);
            base = mixm(a, w1_pix[23:0], base);
        end
        return base;
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: out_rgb=%06h expected=%06h", tag, act, exp);
        end
    endtask

    // One pixel: check the output due now, then drive the next coordinate.
    task automatic step(string tag, int x, int y);
        @(negedge clk);
        if (exp_q.size() == 2) check(tag_q.pop_front(), out_rgb, exp_q.pop_front());
        ras_x = CW'(x);
        ras_y = CW'(y);
        w0_pix = fixed_w0 ? {a0_byte, w0_const}
               : {vary_alpha ? 8'(x * 17) : a0_byte, 8'(x * 16), 8'(y * 40), 8'h33};
        w1_pix = fixed_w1 ? {a1_byte, w1_const}
               : {vary_alpha ? 8'(255 - x * 13) : a1_byte, 8'hC0, 8'(x * 9), 8'(y * 20)};
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    task automatic sweep(string tag);
        for (int y = 0; y < 6; y++)
            for (int x = 0; x < 16; x++)
                step(tag, x, y);
    endtask

    task automatic drain();
        repeat (2) begin
            @(negedge clk);
            if (exp_q.size() > 0) check(tag_q.pop_front(), out_rgb, exp_q.pop_front());
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++;
                bad++;
                $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", out_rgb, 24'h000000);
        rst_n = 1'b1;

        // R3: both windows disabled but covering everything
        w0_left = 0; w0_top = 0; w0_wid = 100; w0_hgt = 100;
        w1_left = 0; w1_top = 0; w1_wid = 100; w1_hgt = 100;
        sweep("R3 disabled");

        // R5/R2/R4/R10: opaque overlapping windows, inclusive edges
        w0_en = 1; w1_en = 1;
        w0_left = 2; w0_top = 1; w0_wid = 8; w0_hgt = 3;
        w1_left = 5; w1_top = 2; w1_wid = 6; w1_hgt = 2;
        sweep("R5 priority R2 R4 R10");

        // R6: per-pixel alpha on both
        vary_alpha = 1; w0_pixalpha = 1; w1_pixalpha = 1;
        sweep("R6 pixel alpha");

        // R7: fixed alpha ignores pixel byte; w1 transparent level, w0 opaque
        vary_alpha = 0; w0_pixalpha = 0; w1_pixalpha = 0;
        a0_byte = 8'h00; a1_byte = 8'hFF;
        w0_fixsel = 1; w1_fixsel = 0;
        sweep("R7 fixed alpha");
        w1_fixsel = 1;

        // R9: window 0 half-blended over background, window 1 off
        w1_en = 0; w0_pixalpha = 1; a0_byte = 8'h80;
        sweep("R9 lower blend");
        w1_en = 1; w0_pixalpha = 0; a0_byte = 8'hFF;

        // R8: exact key match makes window 1 transparent
        fixed_w1 = 1; w1_const = 24'hABCDEF;
        key_en = 1; key_val = 24'hABCDEF; key_mask = 24'hFFFFFF;
        sweep("R8 key full match");
        // R8: mismatch only in masked-out bits still keys
        key_val = 24'hABCD00; key_mask = 24'hFFFF00;
        sweep("R8 key masked match");
        // R8: mismatch in a compared bit leaves window 1 visible
        key_val = 24'hAB0DEF; key_mask = 24'hFFFFFF;
        sweep("R8 key mismatch");
        // R8: window 0 carrying the key colour is not keyed
        fixed_w0 = 1; w0_const = 24'hABCDEF; key_val = 24'hABCDEF;
        w1_en = 0;
        sweep("R8 no key on lower");
        fixed_w0 = 0; fixed_w1 = 0; key_en = 0; w1_en = 1;

        // R2: zero-size window at origin covers (0,0); zero-size at 5 covers nothing
        w1_left = 0; w1_top = 0; w1_wid = 0; w1_hgt = 0;
        w0_left = 5; w0_top = 1; w0_wid = 0; w0_hgt = 3;
        sweep("R2 clamp");
        step("R2 clamp origin", 0, 0);
        step("R2 clamp beside", 1, 0);

        drain();
        finish_run();
    end
endmodule